// File: doc/BRIEF.md
# Periodic Interrupt Timer with Prescaler

This block is a 16-bit periodic interrupt timer that sits on a byte-wide register bus. A power-of-two prescaler divides the bus clock, and the selected tap advances an up-counter. When the counter equals a programmable 16-bit modulo value on a tick, it returns to zero on that tick and latches an overflow flag. The flag drives an interrupt request when interrupts are enabled. Software reads the live count and sets the period through five byte registers at a 3-bit offset. It can halt and resume counting, and it can restart the count from zero with a strobe bit that clears itself.

The overflow flag is held by a three-state machine. `FLAG_CLEAR` moves to `FLAG_SET` on a wrap. `FLAG_SET` moves to `FLAG_ARMED` when software reads the control register. `FLAG_ARMED` moves to `FLAG_CLEAR` when the control register is written with bit 7 at 0, or to `FLAG_SET` if a wrap lands on that same write. Any other write to the control register leaves the state unchanged.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control register reads 0x20 (halted, every other bit 0), the counter reads 0x0000 and the modulo reads 0xFFFF.
- R2: The register offsets are: 0 control, 1 count high byte, 2 count low byte, 3 modulo high byte, 4 modulo low byte. Offsets 5 to 7 read 0. Control bits are: 7 flag, 6 interrupt enable, 5 halt, 4 restart strobe, 3 reads 0, 2:0 rate select. Both modulo bytes read back what was written.
- R3: Rate select value s advances the counter once every 2^s bus clocks for s from 0 to 6. The value 7 behaves like 6 (divide by 64).
- R4: On a tick, the counter increments unless it equals the modulo. In that case it becomes 0, so one period is (modulo+1) ticks.
- R5: The flag becomes 1 on the clock edge where the counter wraps to 0 from the modulo value.
- R6: The interrupt output is 1 exactly when both the flag and interrupt enable are 1.
- R7: The flag clears only when a read of the control register taken while the flag is 1 is followed by a control write with bit 7 at 0. A control write with bit 7 at 0 and no such read leaves the flag at 1. A control write with bit 7 at 1 leaves the flag at 1.
- R8: If a wrap happens on the same edge as the clearing write, the flag stays at 1.
- R9: Writing 1 to control bit 4 sets both the counter and the prescaler to zero on that edge. The bit always reads 0.
- R10: While halt is 1, the counter and the prescaler keep their values. Clearing halt continues from those values.
- R11: Writes to offsets 1 and 2 do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, used to arm the flag clear |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- a wrap is followed by a zero count and a set flag;
- a restart strobe zeroes both the counter and the prescaler;
- the counter and prescaler hold while halted or without a tick;
- writes to the count offsets leave the counter unchanged;
- the flag only falls after a clearing write.

Only the bench scenarios can show the following, because they depend on arithmetic over many ticks or on ordered bus sequences:
- the exact division ratio for each select value, including the aliased encoding;
- the full period length;
- the read-then-write clear protocol;
- the set-wins collision;
- resumption from held values.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int REG_W  = 8;
    localparam int CNT_W  = 16;
    localparam int SEL_W  = 3;
    localparam int PRE_W  = 6;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CNT_H = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CNT_L = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_MOD_H = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MOD_L = 3'd4;

    // control register bit positions
    localparam int BIT_FLAG  = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_HALT  = 5;
    localparam int BIT_RESTART = 4;

    typedef enum logic [1:0] {
        FLAG_CLEAR = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_ARMED = 2'd2
    } flag_state_t;

    typedef struct packed {
        logic             ie;
        logic             halt;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int PRE_W = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick,
    output logic [PRE_W-1:0] presc_q
);
    localparam int NTAPS = 2 ** SEL_W;

    logic [NTAPS-1:0] taps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            presc_q <= '0;
        else if (clr)
            presc_q <= '0;
        else if (run)
            presc_q <= presc_q + 1'b1;
    end

    // tap k fires when the low k prescaler bits are all ones; selects above
    // the prescaler depth alias to the deepest tap
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        if (k == 0) begin : g_direct
            assign taps[k] = 1'b1;
        end else if (k <= PRE_W) begin : g_div
            assign taps[k] = &presc_q[k-1:0];
        end else begin : g_alias
            assign taps[k] = &presc_q;
        end
    end

    always_comb begin
        tick = run && !clr && taps[sel];
    end

    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(presc_q)); // R10

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    always_comb begin
        wrap = tick && (cnt_q == modulo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0)); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q)); // R10
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/pit_flag_fsm.sv
module pit_flag_fsm
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic wr_flag_bit,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (wrap) state_d = FLAG_SET;
            FLAG_SET:   if (stat_rd && !stat_wr) state_d = FLAG_ARMED;
            FLAG_ARMED: if (stat_wr && !wr_flag_bit)
                            state_d = wrap ? FLAG_SET : FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FLAG_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        flag = (state_q != FLAG_CLEAR);
    end

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag); // R5
    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(stat_wr && !wr_flag_bit)); // R7

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int HI_LSB = CNT_W - REG_W;

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  mod_q;
    logic [CNT_W-1:0]  cnt;
    logic [PRE_W-1:0]  presc;
    logic              tick;
    logic              wrap;
    logic              flag;
    logic              ctrl_wr;
    logic              ctrl_rd;
    logic              restart;

    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
        ctrl_rd = bus_rd && (bus_addr == OFS_CTRL);
        restart = ctrl_wr && bus_wdata[BIT_RESTART];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.ie   <= 1'b0;
            ctrl_q.halt <= 1'b1;
            ctrl_q.sel  <= '0;
            mod_q       <= '1;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFS_CTRL: begin
                    ctrl_q.ie   <= bus_wdata[BIT_IE];
                    ctrl_q.halt <= bus_wdata[BIT_HALT];
                    ctrl_q.sel  <= bus_wdata[SEL_W-1:0];
                end
                OFS_MOD_H: mod_q[CNT_W-1:HI_LSB] <= bus_wdata;
                OFS_MOD_L: mod_q[REG_W-1:0]      <= bus_wdata;
                default: ;
            endcase
        end
    end

    pit_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) i_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!ctrl_q.halt),
        .clr     (restart),
        .sel     (ctrl_q.sel),
        .tick    (tick),
        .presc_q (presc)
    );

    pit_counter #(.CNT_W(CNT_W)) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .tick   (tick),
        .modulo (mod_q),
        .cnt_q  (cnt),
        .wrap   (wrap)
    );

    pit_flag_fsm i_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap        (wrap),
        .stat_rd     (ctrl_rd),
        .stat_wr     (ctrl_wr),
        .wr_flag_bit (bus_wdata[BIT_FLAG]),
        .flag        (flag)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL:  bus_rdata = {flag, ctrl_q.ie, ctrl_q.halt, 2'b00, ctrl_q.sel};
            OFS_CNT_H: bus_rdata = cnt[CNT_W-1:HI_LSB];
            OFS_CNT_L: bus_rdata = cnt[REG_W-1:0];
            OFS_MOD_H: bus_rdata = mod_q[CNT_W-1:HI_LSB];
            OFS_MOD_L: bus_rdata = mod_q[REG_W-1:0];
            default:   bus_rdata = '0;
        endcase
        irq = flag && ctrl_q.ie;
    end

    AST_RESTART_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (presc == '0)); // R9
    AST_CNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !tick && !restart &&
         (bus_addr == OFS_CNT_H || bus_addr == OFS_CNT_L)) |=> $stable(cnt)); // R11

endmodule

// File: tb/test_pit_timer.sv
`timescale 1ns/1ps
module test_pit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pit_timer i_pit_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_arm(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic peek_cnt(output int c);
        logic [7:0] h, l;
        peek(3'd1, h);
        peek(3'd2, l);
        c = {h, l};
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        peek(3'd0, d); chk("R1 ctrl reset", d, 8'h20);
        peek_cnt(c);   chk("R1 count reset", c, 0);
        peek(3'd3, d); chk("R1 mod hi reset", d, 8'hFF);
        peek(3'd4, d); chk("R1 mod lo reset", d, 8'hFF);
        peek(3'd5, d); chk("R2 offset 5 reads 0", d, 0);
        chk("R6 irq reset", irq, 0);

        // R11 writes to count offsets ignored
        wr(3'd1, 8'hAA);
        wr(3'd2, 8'h55);
        peek_cnt(c); chk("R11 count unchanged", c, 0);

        // R2 modulo readback
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h02);
        peek(3'd3, d); chk("R2 mod hi readback", d, 8'h00);
        peek(3'd4, d); chk("R2 mod lo readback", d, 8'h02);

        // R3 R4 R5 sweep over all select values with modulo 2
        for (int s = 0; s < 8; s++) begin
            int dv, per;
            dv = 1 << ((s > 6) ? 6 : s);
            per = dv * 3;
            peek(3'd0, d);
            if (d[7]) begin
                rd_arm(3'd0);
                wr(3'd0, 8'h20);
            end
            peek(3'd0, d); chk("R7 flag cleared before sweep", d[7], 0);
            wr(3'd0, 8'h10 | s[7:0]);
            peek(3'd0, d); chk("R9 restart reads 0", d, s);
            for (int n = 1; n <= per + 1; n++) begin
                @(negedge clk);
                peek_cnt(c);
                chk($sformatf("R3 R4 count sel=%0d n=%0d", s, n), c, (n / dv) % 3);
                peek(3'd0, d);
                chk($sformatf("R5 flag sel=%0d n=%0d", s, n), d[7], (n >= per) ? 1 : 0);
                chk("R6 irq off without enable", irq, 0);
            end
        end

        // R6 interrupt gating (flag is set, state not armed)
        wr(3'd0, 8'h60);
        chk("R6 irq with enable", irq, 1);
        wr(3'd0, 8'h20);
        chk("R6 irq enable off", irq, 0);
        peek(3'd0, d); chk("R7 write 0 without read keeps flag", d[7], 1);

        // R7 clear protocol
        rd_arm(3'd0);
        wr(3'd0, 8'hA0);
        peek(3'd0, d); chk("R7 write 1 keeps flag", d[7], 1);
        rd_arm(3'd0);
        wr(3'd0, 8'h20);
        peek(3'd0, d); chk("R7 read then write 0 clears", d[7], 0);
        wr(3'd0, 8'h60);
        chk("R6 irq off when flag clear", irq, 0);

        // R10 halt holds and resume continues
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'h12);
        repeat (5) @(negedge clk);
        wr(3'd0, 8'h22);
        repeat (10) @(negedge clk);
        peek_cnt(c); chk("R10 held count", c, 1);
        wr(3'd0, 8'h02);
        repeat (2) @(negedge clk);
        peek_cnt(c); chk("R10 resumed from held prescaler", c, 2);
        repeat (8) @(negedge clk);
        peek_cnt(c); chk("R10 resumed count", c, 4);

        // R9 restart clears counter and prescaler
        wr(3'd0, 8'h32);
        peek_cnt(c); chk("R9 restart zeroes count", c, 0);
        peek(3'd0, d); chk("R9 strobe bit reads 0", d, 8'h22);
        wr(3'd0, 8'h06);
        repeat (63) @(negedge clk);
        peek_cnt(c); chk("R9 prescaler restarted (63)", c, 0);
        @(negedge clk);
        peek_cnt(c); chk("R9 prescaler restarted (64)", c, 1);

        // R8 set wins over clear: modulo 0 wraps on every tick
        wr(3'd0, 8'h20);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h10);
        repeat (3) @(negedge clk);
        peek(3'd0, d); chk("R5 flag set with modulo 0", d[7], 1);
        rd_arm(3'd0);
        wr(3'd0, 8'h00);
        peek(3'd0, d); chk("R8 set wins over clear", d[7], 1);
        wr(3'd0, 8'h20);

        finish_run();
    end
endmodule